// File: doc/BRIEF.md
# Watchdog Timer with Shared-Prescaler Service Clear

This block is a watchdog timer. A free-running system prescaler counter produces a periodic tick, and each tick advances a small watchdog counter. If software does not service the watchdog, the counter eventually overflows. On that overflow the block raises a one-cycle reset request for the chip's reset controller. Reset sequencing itself is handled elsewhere.

Software services the watchdog by writing any data to the top address of the bus map. A service write clears the watchdog counter. It also clears only a middle slice of the shared prescaler, by default bits 12 down to 5, so the lowest prescaler bits keep running through a service.

The watchdog can be forced off only by decoding high-voltage qualifiers combinationally:

- in monitor mode, a high test voltage on either the reset pin or the interrupt pin turns it off;
- in a break state, a high test voltage on the reset pin turns it off.

The mode inputs alone never disable it.

Top module: `wdt_guard`

## Requirements
- R1: A service happens only on a cycle where `bus_wr_en` is 1 and `bus_addr` equals all ones (0xFFFF by default). Data is not looked at. A write to any other address, or the top address with `bus_wr_en` at 0, has no effect on the timing of reset requests.
- R2: A service write sets the watchdog counter to zero. The next reset request then needs a full run of 2^WD_W ticks.
- R3: A service write clears prescaler bits CLR_HI..CLR_LO (default 12..5). The bits below CLR_LO keep incrementing as if no service took place.
- R4: The prescaler is a PRE_W-bit counter (default 13) that increments every cycle and wraps. It ticks on each cycle in which all of its bits are one, so it ticks once every 2^PRE_W cycles when not serviced.
- R5: Each tick that is not blocked by a service or a disable advances the watchdog counter by one, modulo 2^WD_W (WD_W defaults to 6).
- R6: A tick taken while the watchdog counter is all ones raises `wd_reset_req` in the following cycle. The request is high for exactly one cycle. Without service, requests come every 2^(PRE_W+WD_W) cycles.
- R7: While `monitor_mode` is 1 and either `hv_on_rst_pin` or `hv_on_irq_pin` is 1, the watchdog is off and no request is raised.
- R8: While `break_state` is 1 and `hv_on_rst_pin` is 1, the watchdog is off. A break state with only `hv_on_irq_pin` high does not disable it.
- R9: Neither mode input disables the watchdog without a matching high-voltage qualifier, and neither qualifier does so outside both modes.
- R10: While the watchdog is off, its counter is held at zero. After the disable ends, a full 2^WD_W ticks pass before a request.
- R11: While `rst_n` is 0 at a clock edge, both counters and the request clear.
- R12: When a service and a tick fall on the same cycle, the service wins: the counter clears and no request follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also the prescaler's count clock |
| rst_n | input | 1 | Synchronous active-low system reset |
| bus_wr_en | input | 1 | Bus write strobe |
| bus_addr | input | ADDR_W | Bus write address |
| monitor_mode | input | 1 | Device is in monitor mode |
| break_state | input | 1 | Device is in a break state |
| hv_on_rst_pin | input | 1 | High test voltage detected on the reset pin |
| hv_on_irq_pin | input | 1 | High test voltage detected on the interrupt pin |
| wd_reset_req | output | 1 | One-cycle reset request on watchdog overflow |

## Verification
The assertions assume that `rst_n` is driven to a known value from the first clock edge. They also assume that the mode and high-voltage inputs change only between edges, so that a disable seen at one edge matches the request state observed one cycle later. The bench meets both conditions by holding reset from time zero and changing every input on the falling edge only.

The bench sweeps a small configuration (6-bit prescaler with bits 5..2 cleared, 3-bit watchdog counter). It covers all sixteen qualifier combinations and every service position across one prescaler period. Expected request timing is computed arithmetically from the requirements.

// File: rtl/wdt_pkg.sv
// Package: shared types for the watchdog timer.
// Holds the bundle of disable qualifiers so all submodules agree on layout.
package wdt_pkg;

    // Mode and high-voltage qualifiers that may force the watchdog off.
    typedef struct packed {
        logic monitor;
        logic brk;
        logic hv_rst;
        logic hv_irq;
    } wdt_qual_t;

endpackage

// File: rtl/wdt_prescaler.sv
// Module: wdt_prescaler
// Free-running prescaler counter that issues a tick whenever all of its bits
// are one. A service pulse clears only bits CLR_HI..CLR_LO; every other bit
// keeps following the normal increment.
// Assumes: 0 <= CLR_LO <= CLR_HI < PRE_W; synchronous active-low reset.
module wdt_prescaler #(
    parameter int PRE_W  = 13,
    parameter int CLR_LO = 5,
    parameter int CLR_HI = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic svc_i,
    output logic tick_o
);

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] pre_inc;
    logic [PRE_W-1:0] pre_nxt;

    // Purpose: plain increment of the prescaler value.
    always_comb begin
        pre_inc = pre_q + 1'b1;
    end

    // Per-bit next value: the middle slice is zeroed on service.
    for (genvar i = 0; i < PRE_W; i++) begin : g_bit
        if (i >= CLR_LO && i <= CLR_HI) begin : g_slice
            // Purpose: serviced bits drop to zero, otherwise count.
            always_comb begin
                pre_nxt[i] = svc_i ? 1'b0 : pre_inc[i];
            end
        end else begin : g_free
            // Purpose: bits outside the slice always count.
            always_comb begin
                pre_nxt[i] = pre_inc[i];
            end
        end
    end

    // Purpose: prescaler state register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_nxt;
        end
    end

    // Purpose: tick while the prescaler sits at all ones.
    always_comb begin
        tick_o = &pre_q;
    end

    AST_SLICE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        svc_i |=> (pre_q[CLR_HI:CLR_LO] == '0)); // R3

    if (CLR_LO > 0) begin : g_low_chk
        AST_LOW_BITS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
            rst_n |=> (pre_q[CLR_LO-1:0] == CLR_LO'($past(pre_q[CLR_LO-1:0]) + 1'b1))); // R3
    end

endmodule

// File: rtl/wdt_disable_qual.sv
// Module: wdt_disable_qual
// Purely combinational decode of the disable qualifiers. Only a high-voltage
// detect, together with a matching mode, can turn the watchdog off.
// Assumes: qualifier inputs are already synchronous to clk.
module wdt_disable_qual
    import wdt_pkg::*;
(
    input  wdt_qual_t qual_i,
    output logic      off_o
);

    logic mon_off;
    logic brk_off;

    // Purpose: monitor mode plus either high-voltage pin.
    always_comb begin
        mon_off = qual_i.monitor & (qual_i.hv_rst | qual_i.hv_irq);
    end

    // Purpose: break state plus high voltage on the reset pin only.
    always_comb begin
        brk_off = qual_i.brk & qual_i.hv_rst;
    end

    // Purpose: either condition forces the watchdog off.
    always_comb begin
        off_o = mon_off | brk_off;
    end

endmodule

// File: rtl/wdt_counter.sv
// Module: wdt_counter
// Watchdog counter advanced by prescaler ticks. It is cleared by service or
// disable. A tick at the all-ones count raises a registered one-cycle request.
// Assumes: tick_i is high for one cycle per prescaler period.
module wdt_counter #(
    parameter int WD_W = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic svc_i,
    input  logic off_i,
    output logic req_o
);

    localparam logic [WD_W-1:0] CNT_MAX = '1;

    logic [WD_W-1:0] cnt_q;
    logic            ovf;

    // Purpose: overflow when a live tick meets the full count.
    always_comb begin
        ovf = tick_i & ~svc_i & ~off_i & (cnt_q == CNT_MAX);
    end

    // Purpose: counter state; service and disable have priority over ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (svc_i || off_i) begin
            cnt_q <= '0;
        end else if (tick_i) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Purpose: register the overflow into a one-cycle request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_o <= 1'b0;
        end else begin
            req_o <= ovf;
        end
    end

    AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        req_o |=> !req_o); // R6
    AST_SERVICE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        svc_i |=> (cnt_q == '0 && !req_o)); // R2
    AST_OFF_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        off_i |=> (cnt_q == '0 && !req_o)); // R10
    AST_TICK_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !svc_i && !off_i) |=> (cnt_q == WD_W'($past(cnt_q) + 1'b1))); // R5

endmodule

// File: rtl/wdt_guard.sv
// Module: wdt_guard (top)
// Watchdog timer: prescaler, disable decode and watchdog counter. A bus write
// of any data to the all-ones address services the watchdog.
// Assumes: bus signals are valid for one cycle per write; reset is synchronous.
module wdt_guard #(
    parameter int PRE_W  = 13,
    parameter int CLR_LO = 5,
    parameter int CLR_HI = 12,
    parameter int WD_W   = 6,
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              monitor_mode,
    input  logic              break_state,
    input  logic              hv_on_rst_pin,
    input  logic              hv_on_irq_pin,
    output logic              wd_reset_req
);
    import wdt_pkg::*;

    localparam logic [ADDR_W-1:0] SVC_ADDR = '1;

    logic      svc;
    logic      tick;
    logic      wd_off;
    wdt_qual_t qual;

    // Purpose: decode a service write at the top address.
    always_comb begin
        svc = bus_wr_en & (bus_addr == SVC_ADDR);
    end

    // Purpose: gather the qualifier inputs into the shared bundle.
    always_comb begin
        qual.monitor = monitor_mode;
        qual.brk     = break_state;
        qual.hv_rst  = hv_on_rst_pin;
        qual.hv_irq  = hv_on_irq_pin;
    end

    wdt_prescaler #(
        .PRE_W  (PRE_W),
        .CLR_LO (CLR_LO),
        .CLR_HI (CLR_HI)
    ) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .svc_i  (svc),
        .tick_o (tick)
    );

    wdt_disable_qual u_qual (
        .qual_i (qual),
        .off_o  (wd_off)
    );

    wdt_counter #(
        .WD_W (WD_W)
    ) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (tick),
        .svc_i  (svc),
        .off_i  (wd_off),
        .req_o  (wd_reset_req)
    );

    AST_MONITOR_HV_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (monitor_mode && (hv_on_rst_pin || hv_on_irq_pin)) |=> !wd_reset_req); // R7
    AST_BREAK_HV_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (break_state && hv_on_rst_pin) |=> !wd_reset_req); // R8
    AST_SERVICE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_en && bus_addr == SVC_ADDR) |=> !wd_reset_req); // R12

endmodule

// File: tb/wdt_guard_test.sv
// Bench for wdt_guard in a small configuration. It keeps an arithmetic
// cycle model built from the requirements and compares the request every cycle.
module wdt_guard_test;

    localparam int PRE_W  = 6;
    localparam int CLR_LO = 2;
    localparam int CLR_HI = 5;
    localparam int WD_W   = 3;
    localparam int ADDR_W = 16;
    localparam int PMOD   = 1 << PRE_W;
    localparam int CMOD   = 1 << WD_W;
    localparam int MASK   = ((1 << (CLR_HI + 1)) - 1) & ~((1 << CLR_LO) - 1);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_wr_en = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic              monitor_mode = 1'b0;
    logic              break_state = 1'b0;
    logic              hv_on_rst_pin = 1'b0;
    logic              hv_on_irq_pin = 1'b0;
    logic              wd_reset_req;

    int compared = 0;
    int mismatched = 0;
    int m_pre = 0;
    int m_cnt = 0;
    bit m_req = 1'b0;

    always #5 clk = ~clk;

    wdt_guard #(
        .PRE_W (PRE_W), .CLR_LO (CLR_LO), .CLR_HI (CLR_HI),
        .WD_W (WD_W), .ADDR_W (ADDR_W)
    ) uut (
        .clk (clk), .rst_n (rst_n), .bus_wr_en (bus_wr_en), .bus_addr (bus_addr),
        .monitor_mode (monitor_mode), .break_state (break_state),
        .hv_on_rst_pin (hv_on_rst_pin), .hv_on_irq_pin (hv_on_irq_pin),
        .wd_reset_req (wd_reset_req)
    );

    // One clock: update the model at the edge, compare at the falling edge.
    task automatic step(input string lbl);
        bit off;
        bit svc;
        bit tick;
        @(posedge clk);
        if (!rst_n) begin
            m_pre = 0; m_cnt = 0; m_req = 1'b0;                   // R11
        end else begin
            off  = (monitor_mode && (hv_on_rst_pin || hv_on_irq_pin))  // R7
                || (break_state && hv_on_rst_pin);                     // R8
            svc  = bus_wr_en && (bus_addr == '1);                      // R1
            tick = (m_pre == PMOD - 1);                                // R4
            m_req = tick && (m_cnt == CMOD - 1) && !svc && !off;       // R6 R12
            m_pre = (m_pre + 1) % PMOD;
            if (svc) m_pre = m_pre & ~MASK;                            // R3
            if (svc || off) m_cnt = 0;                                 // R2 R10
            else if (tick) m_cnt = (m_cnt + 1) % CMOD;                 // R5
        end
        @(negedge clk);
        compared++;
        if (wd_reset_req !== m_req) begin
            mismatched++;
            $display("FAIL %s: wd_reset_req actual %b expected %b at %0t",
                     lbl, wd_reset_req, m_req, $time);
        end
    endtask

    task automatic run(input int n, input string lbl);
        for (int i = 0; i < n; i++) step(lbl);
    endtask

    task automatic do_reset(input int n);
        rst_n = 1'b0;
        run(n, "R11 reset");
        rst_n = 1'b1;
    endtask

    task automatic bus_write(input logic [ADDR_W-1:0] a, input logic en, input string lbl);
        bus_wr_en = en; bus_addr = a;
        step(lbl);
        bus_wr_en = 1'b0; bus_addr = '0;
    endtask

    initial begin
        // Reset state and free run: requests every 2^(PRE_W+WD_W) cycles.
        do_reset(5);
        run(1100, "R4 R5 R6 free run");

        // All sixteen qualifier combinations, then release (R7 R8 R9 R10).
        for (int c = 0; c < 16; c++) begin
            do_reset(2);
            monitor_mode  = c[0];
            break_state   = c[1];
            hv_on_rst_pin = c[2];
            hv_on_irq_pin = c[3];
            run(1100, "R7 R8 R9 qualifier sweep");
            run(37, "R10 before release");
            monitor_mode = 1'b0; break_state = 1'b0;
            hv_on_rst_pin = 1'b0; hv_on_irq_pin = 1'b0;
            run(600, "R10 after release");
        end

        // Service at every phase of one prescaler period (R2 R3 R12).
        for (int s = 0; s < PMOD; s++) begin
            do_reset(2);
            run(s + 300, "R5 lead-in");
            bus_write('1, 1'b1, "R1 service");
            run(700, "R2 R3 R12 after service");
        end

        // Writes that must not service (R1).
        do_reset(2);
        for (int k = 0; k < 11; k++) begin
            run(97, "R1 decoy run");
            bus_write(16'hFFFE, 1'b1, "R1 wrong address");
            bus_write(16'h7FFF, 1'b1, "R1 wrong address");
            bus_write('1, 1'b0, "R1 strobe low");
        end

        // Regular servicing keeps the request away (R1 R2).
        do_reset(2);
        for (int k = 0; k < 8; k++) begin
            run(299, "R2 serviced run");
            bus_write('1, 1'b1, "R1 periodic service");
        end

        // Reset in the middle of a run restarts the full period (R11).
        run(200, "R11 pre-reset");
        do_reset(1);
        run(600, "R11 after mid reset");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        #(200000 * 10);
        mismatched++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule